// File: doc/BRIEF.md
# Host-Side ADC Access Sequencer

This block sits on the system side of a parallel successive-approximation converter and drives its chip-enable, active-low chip-select, read/convert and byte-address lines. A one-cycle command asks for a conversion of either full 12-bit length or the short 8-bit length. The sequencer issues the convert strobe and ignores the converter's busy status while that status may still be rising. It then waits for busy to fall and collects the result over an 8-bit data bus. A full conversion is read as a high byte followed by a nibble byte. A short conversion is read as the high byte alone.

Every minimum interval is given as a nanosecond parameter and converted into whole clock cycles, rounded up, so the same RTL meets the converter's rules at any clock period. If busy has not fallen within a bound just above the longest conversion time, the sequencer reports a timeout and returns to idle without delivering a result.

The state machine has nine states. IDLE waits for a start. CONV_SETUP, CONV_PULSE and STS_BLANK issue the convert command and hide the busy flag. BUSY_WAIT waits for busy to fall. RD_SETUP and RD_PULSE perform a byte read. DONE delivers the result and FAULT reports a timeout. The transitions are:
- IDLE→CONV_SETUP on a start.
- CONV_SETUP→CONV_PULSE, CONV_PULSE→STS_BLANK and STS_BLANK→BUSY_WAIT when each interval expires.
- BUSY_WAIT→RD_SETUP when busy is low.
- BUSY_WAIT→FAULT when busy is still high at the end of the timeout.
- RD_SETUP→RD_PULSE when the setup interval expires.
- RD_PULSE→RD_SETUP after the high byte of a full conversion.
- RD_PULSE→DONE after the last read.
- DONE→IDLE and FAULT→IDLE after one cycle.

Top module: `adc_access_seq`

## Requirements
- R1: During and after reset, and whenever the sequencer is idle, `ready_o`=1, `adc_ce_o`=0, `adc_cs_n_o`=1, `adc_rc_o`=1 and `adc_ao_o`=0, with `result_valid_o`=0 and `timeout_o`=0.
- R2: `start_i` is accepted only in a cycle where `ready_o` is 1, and `short_i` is captured in that same cycle. While a conversion is in progress, `start_i` has no effect on any output.
- R3: Before every chip-enable pulse, `adc_cs_n_o` is held low and `adc_rc_o` is held at its command level for exactly SETUP = ceil(max(300 ns, 250 ns)/period) cycles. Both lines stay at those levels until chip-enable falls. The command level is 0 for a convert and 1 for a read.
- R4: Every chip-enable pulse lasts exactly PULSE = ceil(300 ns/period) cycles, whether it is a convert or a read.
- R5: After the convert pulse ends, the busy input is disregarded for BLANK = ceil(400 ns/period) cycles. After that, the first read begins in the cycle after busy is sampled low.
- R6: A full conversion performs two reads. The first read has `adc_ao_o`=0, and its byte becomes result bits 11:4. The second read has `adc_ao_o`=1, and bits 7:4 of its byte become result bits 3:0. Bits 3:0 of the second byte are ignored.
- R7: A short conversion (`short_i`=1) performs only the `adc_ao_o`=0 read and returns that byte in bits 11:4 with bits 3:0 zero.
- R8: During a convert, `adc_ao_o` equals the captured `short_i` (1 selects the 8-bit cycle). During each read, `adc_ao_o` is constant over the whole chip-select interval and never changes while chip-enable is high.
- R9: `result_valid_o` is a single-cycle pulse in the cycle after the last read pulse, with `result_o` valid in that cycle. `ready_o` returns to 1 in the following cycle.
- R10: If busy is still high after ceil((max conversion time + margin)/period) cycles in the wait, `timeout_o` pulses for one cycle and the sequencer returns to idle. The maximum conversion time is 24 µs for short conversions and 35 µs for full ones. No `result_valid_o` is produced for that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request a conversion (taken when ready_o is 1) |
| short_i | input | 1 | 1 selects the 8-bit conversion, 0 the 12-bit one |
| ready_o | output | 1 | Sequencer idle and able to accept a start |
| result_o | output | RES_W (12) | Assembled conversion result |
| result_valid_o | output | 1 | One-cycle strobe qualifying result_o |
| timeout_o | output | 1 | One-cycle strobe: busy did not fall in time |
| adc_ce_o | output | 1 | Converter chip enable, active high |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_rc_o | output | 1 | Converter read (1) / convert (0) |
| adc_ao_o | output | 1 | Converter byte/length address line |
| adc_sts_i | input | 1 | Converter busy status, high while converting |
| adc_data_i | input | BYTE_W (8) | Converter byte-wide data bus |

## Verification
The bench builds the sequencer with a 10 ns period, giving 30-cycle setups, 30-cycle pulses and a 40-cycle blanking window. The maximum conversion times are shortened to 3 µs and 5 µs, which puts the timeouts at 400 and 600 cycles. These shorter limits bring both timeout paths, and recovery after them, within a short run. A converter model drives junk on the bus outside read enables and can place non-zero bits in the nibble byte's trailing half. It can also delay busy past the point where an unblanked sequencer would read early.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CONV_SETUP,
        S_CONV_PULSE,
        S_STS_BLANK,
        S_BUSY_WAIT,
        S_RD_SETUP,
        S_RD_PULSE,
        S_DONE,
        S_FAULT
    } seq_state_t;

    function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int W = 12
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_assemble.sv
module adc_seq_assemble #(
    parameter int BYTE_W = 8,
    parameter int RES_W  = 12
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              clear_i,
    input  logic              take_hi_i,
    input  logic              take_lo_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [RES_W-1:0]  result_o
);

    localparam int LO_W = RES_W - BYTE_W;

    logic [RES_W-1:0] res_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            res_q <= '0;
        end else begin
            if (take_hi_i) begin
                res_q[RES_W-1 -: BYTE_W] <= byte_i;
            end
            if (take_lo_i) begin
                res_q[LO_W-1:0] <= byte_i[BYTE_W-1 -: LO_W];
            end
        end
    end

    assign result_o = res_q;

endmodule

// File: rtl/adc_access_seq.sv
module adc_access_seq
    import adc_seq_pkg::*;
#(
    parameter int CLK_PERIOD_NS     = 10,
    parameter int CS_SETUP_NS       = 300,
    parameter int RC_SETUP_NS       = 250,
    parameter int CE_PULSE_NS       = 300,
    parameter int CS_HOLD_NS        = 200,
    parameter int AO_HOLD_NS        = 300,
    parameter int STS_DELAY_NS      = 400,
    parameter int CONV8_MAX_NS      = 24000,
    parameter int CONV12_MAX_NS     = 35000,
    parameter int TIMEOUT_MARGIN_NS = 1000,
    parameter int BYTE_W            = 8,
    parameter int RES_W             = 12
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic              short_i,
    output logic              ready_o,
    output logic [RES_W-1:0]  result_o,
    output logic              result_valid_o,
    output logic              timeout_o,
    output logic              adc_ce_o,
    output logic              adc_cs_n_o,
    output logic              adc_rc_o,
    output logic              adc_ao_o,
    input  logic              adc_sts_i,
    input  logic [BYTE_W-1:0] adc_data_i
);

    localparam int unsigned CYC_SETUP =
        ns_to_cycles(umax(CS_SETUP_NS, RC_SETUP_NS), CLK_PERIOD_NS);
    localparam int unsigned CYC_PULSE =
        ns_to_cycles(umax(CE_PULSE_NS, umax(CS_HOLD_NS, AO_HOLD_NS)), CLK_PERIOD_NS);
    localparam int unsigned CYC_BLANK = ns_to_cycles(STS_DELAY_NS, CLK_PERIOD_NS);
    localparam int unsigned CYC_TO8   =
        ns_to_cycles(CONV8_MAX_NS + TIMEOUT_MARGIN_NS, CLK_PERIOD_NS);
    localparam int unsigned CYC_TO12  =
        ns_to_cycles(CONV12_MAX_NS + TIMEOUT_MARGIN_NS, CLK_PERIOD_NS);
    localparam int unsigned LONGEST   =
        umax(umax(CYC_TO8, CYC_TO12), umax(CYC_BLANK, umax(CYC_SETUP, CYC_PULSE)));
    localparam int CNT_W = $clog2(LONGEST + 1);

    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(CYC_SETUP - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(CYC_PULSE - 1);
    localparam logic [CNT_W-1:0] LD_BLANK = CNT_W'(CYC_BLANK - 1);
    localparam logic [CNT_W-1:0] LD_TO8   = CNT_W'(CYC_TO8 - 1);
    localparam logic [CNT_W-1:0] LD_TO12  = CNT_W'(CYC_TO12 - 1);

    seq_state_t       state_q, state_d;
    logic             short_q;
    logic             lo_phase_q, lo_phase_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             asm_clear, asm_take_hi, asm_take_lo;

    // State register and command capture
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q    <= S_IDLE;
            short_q    <= 1'b0;
            lo_phase_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            lo_phase_q <= lo_phase_d;
            if (state_q == S_IDLE && start_i) begin
                short_q <= short_i;
            end
        end
    end

    // Transitions, interval loads and capture strobes
    always_comb begin
        state_d     = state_q;
        lo_phase_d  = lo_phase_q;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        asm_clear   = 1'b0;
        asm_take_hi = 1'b0;
        asm_take_lo = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    state_d   = S_CONV_SETUP;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_SETUP;
                    asm_clear = 1'b1;
                end
            end
            S_CONV_SETUP: begin
                if (tmr_zero) begin
                    state_d  = S_CONV_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_PULSE;
                end
            end
            S_CONV_PULSE: begin
                if (tmr_zero) begin
                    state_d  = S_STS_BLANK;
                    tmr_load = 1'b1;
                    tmr_val  = LD_BLANK;
                end
            end
            S_STS_BLANK: begin
                if (tmr_zero) begin
                    state_d  = S_BUSY_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = short_q ? LD_TO8 : LD_TO12;
                end
            end
            S_BUSY_WAIT: begin
                if (!adc_sts_i) begin
                    state_d    = S_RD_SETUP;
                    lo_phase_d = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = LD_SETUP;
                end else if (tmr_zero) begin
                    state_d = S_FAULT;
                end
            end
            S_RD_SETUP: begin
                if (tmr_zero) begin
                    state_d  = S_RD_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_PULSE;
                end
            end
            S_RD_PULSE: begin
                if (tmr_zero) begin
                    asm_take_hi = !lo_phase_q;
                    asm_take_lo = lo_phase_q;
                    if (!lo_phase_q && !short_q) begin
                        state_d    = S_RD_SETUP;
                        lo_phase_d = 1'b1;
                        tmr_load   = 1'b1;
                        tmr_val    = LD_SETUP;
                    end else begin
                        state_d = S_DONE;
                    end
                end
            end
            S_DONE:  state_d = S_IDLE;
            S_FAULT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Pin and strobe decode
    always_comb begin
        ready_o        = 1'b0;
        result_valid_o = 1'b0;
        timeout_o      = 1'b0;
        adc_ce_o       = 1'b0;
        adc_cs_n_o     = 1'b1;
        adc_rc_o       = 1'b1;
        adc_ao_o       = 1'b0;
        unique case (state_q)
            S_IDLE:       ready_o = 1'b1;
            S_CONV_SETUP: begin
                adc_cs_n_o = 1'b0;
                adc_rc_o   = 1'b0;
                adc_ao_o   = short_q;
            end
            S_CONV_PULSE: begin
                adc_ce_o   = 1'b1;
                adc_cs_n_o = 1'b0;
                adc_rc_o   = 1'b0;
                adc_ao_o   = short_q;
            end
            S_STS_BLANK, S_BUSY_WAIT: ;
            S_RD_SETUP: begin
                adc_cs_n_o = 1'b0;
                adc_ao_o   = lo_phase_q;
            end
            S_RD_PULSE: begin
                adc_ce_o   = 1'b1;
                adc_cs_n_o = 1'b0;
                adc_ao_o   = lo_phase_q;
            end
            S_DONE:  result_valid_o = 1'b1;
            S_FAULT: timeout_o      = 1'b1;
            default: ;
        endcase
    end

    adc_seq_timer #(.W(CNT_W)) u_timer (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    adc_seq_assemble #(.BYTE_W(BYTE_W), .RES_W(RES_W)) u_assemble (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .clear_i   (asm_clear),
        .take_hi_i (asm_take_hi),
        .take_lo_i (asm_take_lo),
        .byte_i    (adc_data_i),
        .result_o  (result_o)
    );

endmodule

// File: rtl/adc_access_seq_chk.sv
module adc_access_seq_chk #(
    parameter int SETUP_CYC = 30,
    parameter int PULSE_CYC = 30,
    parameter int BLANK_CYC = 40
) (
    input logic clk_i,
    input logic rst_i,
    input logic ready_o,
    input logic result_valid_o,
    input logic timeout_o,
    input logic adc_ce_o,
    input logic adc_cs_n_o,
    input logic adc_rc_o,
    input logic adc_ao_o
);

    logic [15:0] cs_low_cnt, ce_hi_cnt, since_conv;
    logic        ce_prev, conv_prev;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cs_low_cnt <= '0;
            ce_hi_cnt  <= '0;
            since_conv <= 16'hFFFF;
            ce_prev    <= 1'b0;
            conv_prev  <= 1'b0;
        end else begin
            ce_prev   <= adc_ce_o;
            conv_prev <= adc_ce_o && !adc_rc_o;
            if (adc_cs_n_o)                 cs_low_cnt <= '0;
            else if (cs_low_cnt != 16'hFFFF) cs_low_cnt <= cs_low_cnt + 1'b1;
            if (adc_ce_o && !ce_prev)        ce_hi_cnt <= 16'd1;
            else if (adc_ce_o && ce_hi_cnt != 16'hFFFF) ce_hi_cnt <= ce_hi_cnt + 1'b1;
            if (conv_prev && !adc_ce_o)      since_conv <= '0;
            else if (since_conv != 16'hFFFF) since_conv <= since_conv + 1'b1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        ready_o |-> (!adc_ce_o && adc_cs_n_o && adc_rc_o));

    p_enable_needs_select_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        adc_ce_o |-> !adc_cs_n_o);

    p_select_setup_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(adc_ce_o) |-> (cs_low_cnt >= 16'(SETUP_CYC)));

    p_pulse_width_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(adc_ce_o) |-> (ce_hi_cnt >= 16'(PULSE_CYC)));

    p_status_blank_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(adc_cs_n_o) && adc_rc_o) |-> (since_conv >= 16'(BLANK_CYC)));

    p_addr_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (adc_ce_o && ce_prev) |-> $stable(adc_ao_o));

    p_valid_single_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        result_valid_o |=> !result_valid_o);

    p_timeout_excl_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        timeout_o |-> !result_valid_o);

endmodule

bind adc_access_seq adc_access_seq_chk #(
    .SETUP_CYC (CYC_SETUP),
    .PULSE_CYC (CYC_PULSE),
    .BLANK_CYC (CYC_BLANK)
) u_chk (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .ready_o        (ready_o),
    .result_valid_o (result_valid_o),
    .timeout_o      (timeout_o),
    .adc_ce_o       (adc_ce_o),
    .adc_cs_n_o     (adc_cs_n_o),
    .adc_rc_o       (adc_rc_o),
    .adc_ao_o       (adc_ao_o)
);

// File: tb/adc_access_seq_test.sv
module adc_access_seq_test;

    localparam int CLK_NS   = 10;
    localparam int C8_NS    = 3000;
    localparam int C12_NS   = 5000;
    localparam int MARGIN   = 1000;
    localparam int SET_CYC  = (300 + CLK_NS - 1) / CLK_NS;
    localparam int PUL_CYC  = (300 + CLK_NS - 1) / CLK_NS;
    localparam int BLK_CYC  = (400 + CLK_NS - 1) / CLK_NS;
    localparam int TO8_CYC  = (C8_NS + MARGIN + CLK_NS - 1) / CLK_NS;
    localparam int TO12_CYC = (C12_NS + MARGIN + CLK_NS - 1) / CLK_NS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        short_sel = 1'b0;
    logic        ready, valid, tout, ce, cs_n, rc, ao;
    logic [11:0] result;
    logic        sts = 1'b0;
    logic [7:0]  data_bus;

    // converter model settings (written by the stimulus only)
    logic [11:0] cval = 12'h000;
    logic [3:0]  tail = 4'h0;
    int          conv_len = 100;
    int          sts_lag = 3;

    int n_chk = 0;
    int n_fail = 0;
    int n_valid = 0;
    int n_tout = 0;
    bit cmp_en = 1'b0;

    adc_access_seq #(
        .CLK_PERIOD_NS (CLK_NS),
        .CONV8_MAX_NS  (C8_NS),
        .CONV12_MAX_NS (C12_NS)
    ) uut (
        .clk_i          (clk),
        .rst_i          (rst),
        .start_i        (start),
        .short_i        (short_sel),
        .ready_o        (ready),
        .result_o       (result),
        .result_valid_o (valid),
        .timeout_o      (tout),
        .adc_ce_o       (ce),
        .adc_cs_n_o     (cs_n),
        .adc_rc_o       (rc),
        .adc_ao_o       (ao),
        .adc_sts_i      (sts),
        .adc_data_i     (data_bus)
    );

    always #(CLK_NS / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Converter: data only during a read enable, junk otherwise
    assign data_bus = (ce && !cs_n && rc) ? (ao ? {cval[3:0], tail} : cval[11:4]) : 8'hA5;

    bit cv_run = 1'b0;
    int cv_cnt = 0;
    bit cv_ce_prev = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            cv_run = 1'b0;
            sts    = 1'b0;
        end else if (ce && !cv_ce_prev && !cs_n && !rc) begin
            cv_run = 1'b1;
            cv_cnt = 0;
        end else if (cv_run) begin
            cv_cnt++;
            if (cv_cnt == sts_lag) sts = 1'b1;
            if (cv_cnt == sts_lag + conv_len) begin
                sts    = 1'b0;
                cv_run = 1'b0;
            end
        end
        cv_ce_prev = ce;
    end

    // Reference model: 0 idle,1 conv setup,2 conv pulse,3 blank,4 wait,
    // 5 read setup,6 read pulse,7 done,8 fault
    int m_stage = 0;
    int m_left = 0;
    bit m_short = 1'b0;
    bit m_phase = 1'b0;
    always @(posedge clk) begin
        if (rst) begin
            m_stage = 0; m_left = 0; m_short = 1'b0; m_phase = 1'b0;
        end else begin
            case (m_stage)
                0: if (start) begin m_stage = 1; m_left = SET_CYC - 1; m_short = short_sel; end
                1: if (m_left == 0) begin m_stage = 2; m_left = PUL_CYC - 1; end else m_left--;
                2: if (m_left == 0) begin m_stage = 3; m_left = BLK_CYC - 1; end else m_left--;
                3: if (m_left == 0) begin
                       m_stage = 4;
                       m_left  = (m_short ? TO8_CYC : TO12_CYC) - 1;
                   end else m_left--;
                4: if (!sts) begin m_stage = 5; m_phase = 1'b0; m_left = SET_CYC - 1; end
                   else if (m_left == 0) m_stage = 8;
                   else m_left--;
                5: if (m_left == 0) begin m_stage = 6; m_left = PUL_CYC - 1; end else m_left--;
                6: if (m_left == 0) begin
                       if (!m_phase && !m_short) begin
                           m_stage = 5; m_phase = 1'b1; m_left = SET_CYC - 1;
                       end else m_stage = 7;
                   end else m_left--;
                default: m_stage = 0;
            endcase
        end
    end

    // Per-cycle comparison
    always @(negedge clk) begin
        if (cmp_en) begin
            bit e_ce, e_csn, e_rc, e_ao;
            e_ce  = (m_stage == 2 || m_stage == 6);
            e_csn = !(m_stage == 1 || m_stage == 2 || m_stage == 5 || m_stage == 6);
            e_rc  = !(m_stage == 1 || m_stage == 2);
            e_ao  = (m_stage == 1 || m_stage == 2) ? m_short :
                    (m_stage == 5 || m_stage == 6) ? m_phase : 1'b0;
            chk(ce == e_ce, "R4", "chip enable", ce, e_ce);
            chk(cs_n == e_csn && rc == e_rc, "R3", "select/rc", {cs_n, rc}, {e_csn, e_rc});
            chk(ao == e_ao, "R8", "address line", ao, e_ao);
            chk(ready == (m_stage == 0), "R2", "ready", ready, m_stage == 0);
            chk(valid == (m_stage == 7), "R9", "valid", valid, m_stage == 7);
            chk(tout == (m_stage == 8), "R10", "timeout", tout, m_stage == 8);
            if (valid) n_valid++;
            if (tout) n_tout++;
        end
    end

    task automatic run_conv(input bit sh, input logic [11:0] v, input int len,
                            input int lag, input logic [3:0] tl, input int hold,
                            input bit expect_to, input string req);
        int v0, t0;
        logic [11:0] exp_res;
        bit seen;
        @(negedge clk);
        cval = v; conv_len = len; sts_lag = lag; tail = tl;
        short_sel = sh; start = 1'b1;
        v0 = n_valid; t0 = n_tout;
        exp_res = sh ? {v[11:4], 4'h0} : v;
        seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (i + 1 >= hold) start = 1'b0;
            if (valid && !seen) begin
                seen = 1'b1;
                chk(result == exp_res, req, "result", result, exp_res);
            end
            if (valid || tout) break;
        end
        start = 1'b0;
        @(negedge clk);
        if (expect_to) begin
            chk(n_tout == t0 + 1 && n_valid == v0, "R10", "timeout without result",
                n_valid - v0, 0);
        end else begin
            chk(seen && n_tout == t0, req, "completed once", n_valid - v0, 1);
        end
        while (cv_run) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(ready == 1'b1, "R1", "back to idle", ready, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(ready == 1'b1 && ce == 1'b0 && cs_n == 1'b1 && rc == 1'b1 && ao == 1'b0
            && valid == 1'b0 && tout == 1'b0, "R1", "reset levels",
            {ready, ce, cs_n, rc, ao, valid, tout}, 7'b1011000);
        rst = 1'b0;
        cmp_en = 1'b1;
        repeat (3) @(negedge clk);

        run_conv(1'b0, 12'hABC, 200, 3, 4'h0, 1, 1'b0, "R6");
        run_conv(1'b1, 12'h5E7, 120, 3, 4'h0, 1, 1'b0, "R7");
        run_conv(1'b0, 12'h0F0, 150, 2, 4'hF, 1, 1'b0, "R6");
        run_conv(1'b0, 12'h000, 80,  4, 4'h9, 1, 1'b0, "R6");
        run_conv(1'b0, 12'h36D, 150, 65, 4'h0, 1, 1'b0, "R5");
        run_conv(1'b1, 12'hFFF, 100, 3, 4'hF, 60, 1'b0, "R2");
        run_conv(1'b0, 12'h123, 700, 3, 4'h0, 1, 1'b1, "R10");
        run_conv(1'b1, 12'h456, 500, 3, 4'h0, 1, 1'b1, "R10");
        run_conv(1'b0, 12'hFED, 250, 3, 4'h0, 1, 1'b0, "R9");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule